// File: doc/BRIEF.md
# Serial DAC Input and Load Register Front End

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. An external controller selects the block with an active-low select, clocks a code in one bit per serial clock rising edge, and then pulses a load strobe. The load strobe moves the received code from a holding (input) register into the conversion (DAC) register that drives the converter core. Because the two registers are separate, a new code can be shifted in while the previous one is still being converted. All updates of the output happen at the load strobe. The code is straight binary for unipolar use and offset binary for bipolar use. 0x8000 is half scale, which is bipolar zero.

All serial pins are sampled by a much faster system clock through synchronizers, and edges are found by comparing successive samples. The system clock must run at least four times faster than the serial clock. The bit leaving the top of the holding register appears on the serial output, so several devices can be chained. A clear pin, active low, forces both registers to a level chosen by a clear-level pin, and the converter code follows at once. A saturating bit counter reports transfer length. One edge quirk of the serial bus is kept: if the select is released while the serial clock is low, that release counts as a shift edge.

Top module: `sdac_frontend`

## Requirements
- R1: While `csel_n` is high, serial clock edges do not shift the holding register and `ser_dout_en` is 0.
- R2: While `csel_n` is low, each rising edge of `ser_clk` shifts `ser_din` into bit 0 of the holding register, with older bits moving toward bit 15, so a 16-bit word arrives most significant bit first.
- R3: A rising edge of `csel_n` that occurs while `ser_clk` is low shifts one extra bit (the current `ser_din`) into the holding register and counts it.
- R4: A rising edge of `load_strobe` copies the holding register into the DAC register whatever the level of `csel_n`. `dac_code` changes at no other time except reset.
- R5: While `clr_n` is low, both registers are set to 0x8000 when `clr_mid` is 1 and to 0x0000 when `clr_mid` is 0, and `dac_code` shows that value without waiting for a clock.
- R6: While `clr_n` is low, shift and load edges have no effect.
- R7: When a shift edge and a load edge are detected in the same system clock cycle, the DAC register takes the holding register value from before that shift.
- R8: `ser_dout` carries bit 15 of the holding register, so the word held before a transfer appears on it, most significant bit first, during the next 16 shifts. `ser_dout_en` is 1 while `csel_n` is low.
- R9: `bit_count` is cleared when `csel_n` falls and counts shift edges after that, saturating at 31.
- R10: The synchronous system reset `rst` returns both registers to the level selected by `clr_mid`, clears `bit_count`, and puts the sampled pins in their idle state (select high, serial clock high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high system reset |
| csel_n | input | 1 | Active-low device select |
| ser_clk | input | 1 | Serial clock; rising edges shift |
| ser_din | input | 1 | Serial data in |
| load_strobe | input | 1 | Rising edge loads the DAC register |
| clr_n | input | 1 | Active-low clear of both registers |
| clr_mid | input | 1 | Clear level: 1 for 0x8000, 0 for 0x0000 |
| ser_dout | output | 1 | Top bit of the holding register |
| ser_dout_en | output | 1 | Output enable for ser_dout (1 drives) |
| dac_code | output | 16 | Code presented to the converter core |
| bit_count | output | 5 | Shifts since select fell, saturating at 31 |

## Verification
The hardest case to reach from the pins is R7, where a shift edge and a load edge have to land in the same system clock cycle after passing through separate synchronizers. The stimulus first leaves a known word in the holding register that differs from the DAC register. It then raises `ser_clk` and `load_strobe` at the same instant, so both sampled edges appear in one cycle, and it expects the DAC register to get the word from before the shift. The select-release quirk of R3 is reached by ending a 15-bit transfer with the serial clock parked low.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int CODE_W = 16;
    localparam int CNT_W  = 5;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Sampled pin bundle (order fixes the packed layout used by the synchronizer)
    typedef struct packed {
        logic csel_n;
        logic sck;
        logic din;
        logic ld;
    } pins_t;

    localparam int    PINS_W    = $bits(pins_t);
    localparam pins_t PINS_IDLE = '{csel_n: 1'b1, sck: 1'b1, din: 1'b0, ld: 1'b0};

    // Per-cycle events found by the edge stage
    typedef struct packed {
        logic shift;
        logic load;
        logic frame_start;
    } ev_t;

    function automatic code_t clear_code(input logic mid);
        return mid ? (code_t'(1) << (CODE_W - 1)) : '0;
    endfunction

    function automatic cnt_t sat_inc(input cnt_t c);
        return (&c) ? c : c + cnt_t'(1);
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= RST_VAL;
                    else     stage[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= RST_VAL;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
    import sdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t cur,
    output ev_t   ev
);
    pins_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= PINS_IDLE;
        else     prev <= cur;
    end

    logic sck_rise, cs_rise, ld_rise;
    always_comb begin
        sck_rise       = cur.sck    & ~prev.sck;
        cs_rise        = cur.csel_n & ~prev.csel_n;
        ld_rise        = cur.ld     & ~prev.ld;
        // Normal shift while selected, plus the release-with-clock-low quirk
        ev.shift       = (sck_rise & ~cur.csel_n) | (cs_rise & ~cur.sck);
        ev.load        = ld_rise;
        ev.frame_start = ~cur.csel_n & prev.csel_n;
    end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_n,
    input  logic  clr_mid,
    input  ev_t   ev,
    input  logic  din,
    output code_t hold_q,
    output code_t conv_q,
    output cnt_t  cnt_q
);
    always_ff @(posedge clk) begin
        if (rst || !clr_n) begin
            hold_q <= clear_code(clr_mid);
            conv_q <= clear_code(clr_mid);
            cnt_q  <= '0;
        end else begin
            if (ev.shift) hold_q <= {hold_q[CODE_W-2:0], din};
            if (ev.load)  conv_q <= hold_q;   // pre-shift value on a same-cycle shift
            if (ev.frame_start) cnt_q <= ev.shift ? cnt_t'(1) : '0;
            else if (ev.shift)  cnt_q <= sat_inc(cnt_q);
        end
    end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csel_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              load_strobe,
    input  logic              clr_n,
    input  logic              clr_mid,
    output logic              ser_dout,
    output logic              ser_dout_en,
    output logic [CODE_W-1:0] dac_code,
    output logic [CNT_W-1:0]  bit_count
);
    pins_t raw, syn;
    ev_t   ev_w;
    code_t hold_q, conv_q;
    cnt_t  cnt_q;

    always_comb begin
        raw.csel_n = csel_n;
        raw.sck    = ser_clk;
        raw.din    = ser_din;
        raw.ld     = load_strobe;
    end

    logic [PINS_W-1:0] syn_bits;

    sdac_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn_bits)
    );

    assign syn = pins_t'(syn_bits);

    sdac_edge u_edge (
        .clk (clk),
        .rst (rst),
        .cur (syn),
        .ev  (ev_w)
    );

    sdac_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .clr_n   (clr_n),
        .clr_mid (clr_mid),
        .ev      (ev_w),
        .din     (syn.din),
        .hold_q  (hold_q),
        .conv_q  (conv_q),
        .cnt_q   (cnt_q)
    );

    assign dac_code    = clr_n ? conv_q : clear_code(clr_mid);
    assign ser_dout    = hold_q[CODE_W-1];
    assign ser_dout_en = ~syn.csel_n;
    assign bit_count   = cnt_q;
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk
    import sdac_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  clr_n,
    input logic  clr_mid,
    input logic  shift,
    input logic  load,
    input logic  frame_start,
    input logic  cs_high,
    input logic  din,
    input code_t hold_q,
    input code_t conv_q,
    input cnt_t  cnt_q
);
    // R1: hold register untouched while select stays high without a release edge
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (clr_n && cs_high && !shift) |=> $stable(hold_q));

    // R2: a shift moves the register up by one and takes the sampled data bit
    a_r2_shift_order: assert property (@(posedge clk) disable iff (rst)
        (clr_n && shift) |=> (hold_q == {$past(hold_q[CODE_W-2:0]), $past(din)}));

    // R4: conversion register changes only on a load
    a_r4_load_only: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !load) |=> $stable(conv_q));

    // R7: load takes the pre-shift holding value
    a_r7_load_preshift: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load) |=> (conv_q == $past(hold_q)));

    // R5: clear forces the selected level into the conversion register
    a_r5_clear_level: assert property (@(posedge clk) disable iff (rst)
        (!clr_n) |=> (conv_q == clear_code($past(clr_mid))));

    // R9: saturated counter stays at its ceiling until a new frame
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (clr_n && (&cnt_q) && !frame_start) |=> (&cnt_q));
endmodule

bind sdac_frontend sdac_frontend_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_n       (clr_n),
    .clr_mid     (clr_mid),
    .shift       (ev_w.shift),
    .load        (ev_w.load),
    .frame_start (ev_w.frame_start),
    .cs_high     (syn.csel_n),
    .din         (syn.din),
    .hold_q      (hold_q),
    .conv_q      (conv_q),
    .cnt_q       (cnt_q)
);

// File: tb/sdac_frontend_tb.sv
module sdac_frontend_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csel_n = 1'b1, ser_clk = 1'b1, ser_din = 1'b0, load_strobe = 1'b0;
    logic        clr_n = 1'b1, clr_mid = 1'b1;
    logic        ser_dout, ser_dout_en;
    logic [15:0] dac_code;
    logic [4:0]  bit_count;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] exp_q[$];
    logic [15:0] last_code;
    logic [15:0] mdl = 16'h8000;   // bench model of the holding register
    logic [15:0] cap;
    bit          mon_on = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sdac_frontend u_dut (
        .clk(clk), .rst(rst), .csel_n(csel_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .load_strobe(load_strobe), .clr_n(clr_n), .clr_mid(clr_mid),
        .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
        .dac_code(dac_code), .bit_count(bit_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every change of dac_code must match the next expected item
    always @(posedge clk) begin
        #1;
        if (mon_on && dac_code !== last_code) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected dac_code change", dac_code, last_code);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(dac_code == e, "R4 dac_code update", dac_code, e);
            end
            last_code = dac_code;
        end
    end

    task automatic sbit(input logic b);
        ser_clk = 1'b0; ser_din = b; tick(4);
        cap = {cap[14:0], ser_dout};
        ser_clk = 1'b1; tick(4);
        if (!csel_n && clr_n) mdl = {mdl[14:0], b};
    endtask

    task automatic frame(input logic [15:0] w, input int nbits);
        csel_n = 1'b0; tick(4);
        for (int i = 0; i < nbits; i++) sbit(w[15 - (i % 16)]);
    endtask

    task automatic end_frame();
        csel_n = 1'b1; tick(6);
    endtask

    task automatic load_push();
        exp_q.push_back(mdl);
        load_strobe = 1'b1; tick(4);
        load_strobe = 1'b0; tick(4);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(4);
        // R10 reset state
        chk(dac_code == 16'h8000, "R10 reset code", dac_code, 16'h8000);
        chk(ser_dout_en == 1'b0, "R10/R1 idle output enable", ser_dout_en, 0);
        chk(bit_count == 5'd0, "R10 reset count", bit_count, 0);
        last_code = dac_code;
        mon_on = 1'b1;

        // R2/R9/R8: full transfer, MSB first; old word 0x8000 shifts out
        cap = '0;
        frame(16'h1234, 16);
        chk(ser_dout_en == 1'b1, "R8 output enable while selected", ser_dout_en, 1);
        chk(bit_count == 5'd16, "R9 count after 16 bits", bit_count, 16);
        chk(cap == 16'h8000, "R8 chained output word", cap, 16'h8000);
        end_frame();
        chk(bit_count == 5'd16, "R9 count after release", bit_count, 16);
        load_push();                              // R2 expects 0x1234

        // R8: previous word 0x1234 appears on ser_dout during next transfer
        cap = '0;
        frame(16'hA5C3, 16);
        chk(cap == 16'h1234, "R8 chained output word", cap, 16'h1234);
        end_frame();
        // R1: clock activity while deselected is ignored
        for (int i = 0; i < 5; i++) begin
            ser_clk = 1'b0; ser_din = i[0]; tick(4);
            ser_clk = 1'b1; tick(4);
        end
        chk(ser_dout_en == 1'b0, "R1 output enable while deselected", ser_dout_en, 0);
        chk(bit_count == 5'd16, "R1 count unchanged while deselected", bit_count, 16);
        load_push();                              // R1 expects 0xA5C3

        // R3: 15 bits, then release while serial clock is low
        frame(16'h3C5A, 15);
        ser_clk = 1'b0; ser_din = 1'b0; tick(4);
        csel_n = 1'b1; tick(6);
        mdl = {mdl[14:0], 1'b0};
        ser_clk = 1'b1; tick(4);
        chk(bit_count == 5'd16, "R3 extra bit counted", bit_count, 16);
        chk(mdl == 16'h3C5A, "R3 bench model word", mdl, 16'h3C5A);
        load_push();                              // R3 expects 0x3C5A

        // R5: clear to zero, immediate on dac_code
        clr_mid = 1'b0;
        exp_q.push_back(16'h0000);
        clr_n = 1'b0; #1;
        chk(dac_code == 16'h0000, "R5 immediate clear to zero", dac_code, 0);
        tick(4);
        // R6: shifts and loads during clear are ignored
        frame(16'hFFFF, 16);
        load_strobe = 1'b1; tick(4); load_strobe = 1'b0; tick(4);
        end_frame();
        clr_n = 1'b1; tick(4);
        mdl = 16'h0000;
        csel_n = 1'b0; tick(6);
        chk(ser_dout == 1'b0, "R6 holding register still cleared", ser_dout, 0);
        csel_n = 1'b1; tick(6);
        load_strobe = 1'b1; tick(4); load_strobe = 1'b0; tick(4);
        chk(dac_code == 16'h0000, "R6 load after clear", dac_code, 0);

        // R5: clear to mid-scale, holding register too
        clr_mid = 1'b1;
        exp_q.push_back(16'h8000);
        clr_n = 1'b0; #1;
        chk(dac_code == 16'h8000, "R5 immediate clear to mid", dac_code, 16'h8000);
        tick(4);
        clr_n = 1'b1; tick(4);
        mdl = 16'h8000;
        csel_n = 1'b0; tick(6);
        chk(ser_dout == 1'b1, "R5 holding register at mid", ser_dout, 1);
        csel_n = 1'b1; tick(6);

        // R7: shift and load edges in the same cycle
        frame(16'h6E29, 16);
        ser_clk = 1'b0; ser_din = 1'b1; tick(4);
        exp_q.push_back(16'h6E29);
        ser_clk = 1'b1; load_strobe = 1'b1; tick(6);
        mdl = {mdl[14:0], 1'b1};
        load_strobe = 1'b0; tick(4);
        chk(dac_code == 16'h6E29, "R7 load takes pre-shift word", dac_code, 16'h6E29);
        end_frame();

        // R9: saturation at 31
        frame(16'h0F0F, 40);
        chk(bit_count == 5'd31, "R9 count saturates", bit_count, 31);
        end_frame();
        csel_n = 1'b0; tick(6);
        chk(bit_count == 5'd0, "R9 count cleared on select", bit_count, 0);
        csel_n = 1'b1; tick(6);

        tick(8);
        chk(exp_q.size() == 0, "R4 all expected updates seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule